// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block takes one configuration request from a host (bus number, device number, function number, register offset, access size, direction and write data) and turns it into a PCI configuration transaction. It forms the configuration address in Type 0 form, with a one-hot device select, or in Type 1 form for buses behind a bridge. It also builds the active-low byte-enable field, moves write data onto the addressed byte lanes and moves the returned read data down to bit 0.

A request for bus 0, device 0, function 0 does not reach the external bus. It is steered to a local path that serves the host bridge's own configuration space, and that path packs offset, direction and byte enables into a single command word. Every external access ends with a response that carries a 2-bit master-side error code and a 1-bit slave-side error flag. Nonzero error bits collect in sticky status registers together with the address of the first failing access, and they stay there until software writes the same bits back. A failed read returns all ones, and a failed write never reaches its data phase.

The bus itself is represented by a small request/response interface. One transaction is handled at a time, and `busy` stays high from acceptance until the one-cycle `done` pulse.

Top module: `pcicfg_seq`

## Requirements
- R1: When the bus number is 0 and the target is not the local bridge, `ext_addr` equals (1 << device) OR (function << 8) OR (register with bits 1:0 cleared). Bit 0 is 0 in this form.
- R2: When the bus number is nonzero, `ext_addr` equals (bus << 16) OR (device << 11) OR (function << 8) OR (register with bits 1:0 cleared) OR 1.
- R3: Byte enables are 4 bits wide and active low, with bit i standing for byte lane i. Size 4 gives 0000. Size 1 clears only bit (reg mod 4). Size 2 clears bits (reg mod 4) and (reg mod 4)+1, and anything shifted past bit 3 is dropped. `ext_cmd[7:4]` carries the byte enables and `ext_cmd[3:0]` carries the command code: 4'hA for a read, 4'hB for a write.
- R4: A size other than 1, 2 or 4 is illegal. Such a request completes with `rsp_illegal`=1 and `rsp_rdata`=FFFFFFFF, and it raises neither `ext_req` nor `loc_req`.
- R5: Bus 0, device 0, function 0 goes only to the local path. `loc_cmd` then holds the aligned offset in bits 7:0, 1 for a write in bit 16 and the byte enables in bits 23:20, and `ext_req` stays low.
- R6: The data driven on `xfer_wdata` is the request's write data shifted left by 8*(reg mod 4).
- R7: Read data from either path is returned on `rsp_rdata` shifted right by 8*(reg mod 4), with zeros filled in at the top.
- R8: Nonzero response error bits are ORed into `mst_err_stat` and `slv_err_stat` and stay set. A clear with `clr_valid` drops only the bits that are 1 in `clr_mst` and `clr_slv`.
- R9: `err_addr` captures `ext_addr` when an error arrives while both status registers are zero, and it does not change while any status bit is set.
- R10: An external response with any error bit set completes the request with `rsp_err`=1. A read then returns FFFFFFFF, and a write never raises `ext_wr`.
- R11: A request is accepted only while `busy` is low, and a request presented while busy is dropped. `busy` stays high from acceptance until `done`, and `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_reg | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Transaction in flight |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result |
| rsp_err | output | 1 | Completed with a bus error |
| rsp_illegal | output | 1 | Rejected for an illegal size |
| clr_valid | input | 1 | Status clear strobe |
| clr_mst | input | 2 | Master-side status bits to clear |
| clr_slv | input | 1 | Slave-side status bit to clear |
| mst_err_stat | output | 2 | Sticky master-side error status |
| slv_err_stat | output | 1 | Sticky slave-side error status |
| err_addr | output | 32 | Address of first failing access |
| ext_req | output | 1 | External setup phase request |
| ext_addr | output | 32 | Configuration address |
| ext_cmd | output | 8 | Byte enables and command code |
| ext_resp | input | 1 | External setup response |
| ext_rdata | input | 32 | External read data |
| ext_mst_err | input | 2 | Master-side error code |
| ext_slv_err | input | 1 | Slave-side error flag |
| ext_wr | output | 1 | External write data phase strobe |
| xfer_wdata | output | 32 | Lane-aligned write data |
| loc_req | output | 1 | Local configuration request |
| loc_cmd | output | 32 | Local command word |
| loc_ack | input | 1 | Local path acknowledge |
| loc_rdata | input | 32 | Local read data |

## Verification
The hardest case to reach is a second error, or a status clear, arriving while an earlier error is still pending, since that is the only time `err_addr` must ignore a fresh faulting address. The bench gets there by running two failing accesses to different unmapped devices in a row and checking that the address of the first one survives. It then clears the wrong status bit on purpose and checks that nothing was cleared. Dropping of requests presented while busy is reached by driving a second request on the cycle right after acceptance and counting bus setups and `done` pulses.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DPHASE,
    ST_LOCAL,
    ST_DONE
  } seq_state_t;

  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  localparam int LOC_WR_BIT = 16;
  localparam int LOC_BE_LSB = 20;
  localparam int T1_BUS_LSB = 16;
  localparam int T1_DEV_LSB = 11;
  localparam int FUNC_LSB   = 8;
endpackage

// File: rtl/pcicfg_addr_gen.sv
module pcicfg_addr_gen #(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [REG_W-1:0]  regno,
  input  logic [2:0]        size,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [REG_W-1:0]  reg_aligned,
  output logic [BE_W-1:0]   be_n,
  output logic              size_ok,
  output logic              to_local
);
  import pcicfg_pkg::*;
  localparam int OFF_W = $clog2(BE_W);

  logic [OFF_W-1:0] off;
  assign off = regno[OFF_W-1:0];

  always_comb begin
    reg_aligned = {regno[REG_W-1:OFF_W], {OFF_W{1'b0}}};
    if (bus == '0) begin
      cfg_addr = (ADDR_W'(1) << dev)
               | (ADDR_W'(func) << FUNC_LSB)
               | ADDR_W'(reg_aligned);
    end else begin
      cfg_addr = (ADDR_W'(bus) << T1_BUS_LSB)
               | (ADDR_W'(dev) << T1_DEV_LSB)
               | (ADDR_W'(func) << FUNC_LSB)
               | ADDR_W'(reg_aligned)
               | ADDR_W'(1);
    end
  end

  always_comb begin
    size_ok = 1'b1;
    case (size)
      3'd1:    be_n = ~(BE_W'(1) << off);
      3'd2:    be_n = ~(BE_W'(3) << off);
      3'd4:    be_n = '0;
      default: begin
        be_n    = '1;
        size_ok = 1'b0;
      end
    endcase
  end

  assign to_local = (bus == '0) && (dev == '0) && (func == '0);
endmodule

// File: rtl/pcicfg_lane.sv
module pcicfg_lane #(
  parameter int DATA_W   = 32,
  parameter bit SHIFT_UP = 1'b1
) (
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]           din,
  output logic [DATA_W-1:0]           dout
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] amt;
  assign amt = SH_W'({off, 3'b000});

  generate
    if (SHIFT_UP) begin : g_up
      assign dout = din << amt;
    end else begin : g_down
      assign dout = din >> amt;
    end
  endgenerate
endmodule

// File: rtl/pcicfg_err_track.sv
module pcicfg_err_track #(
  parameter int ADDR_W = 32,
  parameter int MST_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [MST_W-1:0]  new_mst,
  input  logic              new_slv,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              clr_valid,
  input  logic [MST_W-1:0]  clr_mst,
  input  logic              clr_slv,
  output logic [MST_W-1:0]  mst_stat,
  output logic              slv_stat,
  output logic [ADDR_W-1:0] err_addr
);
  logic [MST_W-1:0] mst_nxt;
  logic             slv_nxt;
  logic             any_new;
  logic             quiet;

  always_comb begin
    mst_nxt = clr_valid ? (mst_stat & ~clr_mst) : mst_stat;
    slv_nxt = clr_valid ? (slv_stat & ~clr_slv) : slv_stat;
    if (cap) begin
      mst_nxt = mst_nxt | new_mst;
      slv_nxt = slv_nxt | new_slv;
    end
  end

  assign any_new = cap && ((new_mst != '0) || new_slv);
  assign quiet   = (mst_stat == '0) && !slv_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_stat <= '0;
      slv_stat <= 1'b0;
      err_addr <= '0;
    end else begin
      mst_stat <= mst_nxt;
      slv_stat <= slv_nxt;
      if (any_new && quiet) err_addr <= cap_addr;
    end
  end
endmodule

// File: rtl/pcicfg_seq.sv
module pcicfg_seq #(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int REG_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int MST_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [2:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_illegal,
  input  logic              clr_valid,
  input  logic [MST_W-1:0]  clr_mst,
  input  logic              clr_slv,
  output logic [MST_W-1:0]  mst_err_stat,
  output logic              slv_err_stat,
  output logic [ADDR_W-1:0] err_addr,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [7:0]        ext_cmd,
  input  logic              ext_resp,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic [MST_W-1:0]  ext_mst_err,
  input  logic              ext_slv_err,
  output logic              ext_wr,
  output logic [DATA_W-1:0] xfer_wdata,
  output logic              loc_req,
  output logic [31:0]       loc_cmd,
  input  logic              loc_ack,
  input  logic [DATA_W-1:0] loc_rdata
);
  import pcicfg_pkg::*;
  localparam int BE_W  = DATA_W / 8;
  localparam int OFF_W = $clog2(BE_W);

  seq_state_t       state;
  logic             write_q;
  logic [OFF_W-1:0] off_q;

  logic [ADDR_W-1:0] gen_addr;
  logic [REG_W-1:0]  gen_reg_al;
  logic [BE_W-1:0]   gen_be_n;
  logic              gen_size_ok;
  logic              gen_local;
  logic [DATA_W-1:0] wr_aligned;
  logic [DATA_W-1:0] rd_src;
  logic [DATA_W-1:0] rd_aligned;
  logic [31:0]       loc_word;
  logic              accept;
  logic              resp_fail;

  pcicfg_addr_gen #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W),
    .REG_W(REG_W), .ADDR_W(ADDR_W), .BE_W(BE_W)
  ) u_addr (
    .bus(req_bus), .dev(req_dev), .func(req_func), .regno(req_reg),
    .size(req_size), .cfg_addr(gen_addr), .reg_aligned(gen_reg_al),
    .be_n(gen_be_n), .size_ok(gen_size_ok), .to_local(gen_local)
  );

  pcicfg_lane #(.DATA_W(DATA_W), .SHIFT_UP(1'b1)) u_wr_lane (
    .off(req_reg[OFF_W-1:0]), .din(req_wdata), .dout(wr_aligned)
  );

  assign rd_src = (state == ST_LOCAL) ? loc_rdata : ext_rdata;

  pcicfg_lane #(.DATA_W(DATA_W), .SHIFT_UP(1'b0)) u_rd_lane (
    .off(off_q), .din(rd_src), .dout(rd_aligned)
  );

  pcicfg_err_track #(.ADDR_W(ADDR_W), .MST_W(MST_W)) u_err (
    .clk(clk), .rst(rst),
    .cap((state == ST_SETUP) && ext_resp),
    .new_mst(ext_mst_err), .new_slv(ext_slv_err), .cap_addr(ext_addr),
    .clr_valid(clr_valid), .clr_mst(clr_mst), .clr_slv(clr_slv),
    .mst_stat(mst_err_stat), .slv_stat(slv_err_stat), .err_addr(err_addr)
  );

  always_comb begin
    loc_word = '0;
    loc_word[REG_W-1:0] = gen_reg_al;
    loc_word[LOC_WR_BIT] = req_write;
    loc_word[LOC_BE_LSB +: BE_W] = gen_be_n;
  end

  assign accept    = req_valid && (state == ST_IDLE);
  assign resp_fail = (ext_mst_err != '0) || ext_slv_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      write_q     <= 1'b0;
      off_q       <= '0;
      ext_addr    <= '0;
      ext_cmd     <= '0;
      loc_cmd     <= '0;
      xfer_wdata  <= '0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      rsp_illegal <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            write_q     <= req_write;
            off_q       <= req_reg[OFF_W-1:0];
            ext_addr    <= gen_addr;
            ext_cmd     <= {gen_be_n, req_write ? CMD_CFG_WR : CMD_CFG_RD};
            loc_cmd     <= loc_word;
            xfer_wdata  <= wr_aligned;
            rsp_err     <= 1'b0;
            rsp_illegal <= !gen_size_ok;
            if (!gen_size_ok) begin
              rsp_rdata <= '1;
              state     <= ST_DONE;
            end else if (gen_local) begin
              state <= ST_LOCAL;
            end else begin
              state <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (ext_resp) begin
            rsp_err   <= resp_fail;
            rsp_rdata <= resp_fail ? '1 : rd_aligned;
            if (!resp_fail && write_q) state <= ST_DPHASE;
            else                       state <= ST_DONE;
          end
        end
        ST_DPHASE: state <= ST_DONE;
        ST_LOCAL: begin
          if (loc_ack) begin
            rsp_rdata <= rd_aligned;
            state     <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign ext_req = (state == ST_SETUP);
  assign ext_wr  = (state == ST_DPHASE);
  assign loc_req = (state == ST_LOCAL);
endmodule

// File: rtl/pcicfg_seq_chk.sv
module pcicfg_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int MST_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              ext_req,
  input logic              ext_wr,
  input logic              loc_req,
  input logic              ext_resp,
  input logic [MST_W-1:0]  ext_mst_err,
  input logic              ext_slv_err,
  input logic [7:0]        ext_cmd,
  input logic [MST_W-1:0]  mst_err_stat,
  input logic              slv_err_stat,
  input logic [ADDR_W-1:0] err_addr,
  input logic              clr_valid
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_BUS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ext_req || ext_wr || loc_req) |-> busy); // R11
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    !(ext_req && loc_req)); // R5
  AST_CMD_CODE: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> (ext_cmd[3:0] == 4'hA || ext_cmd[3:0] == 4'hB)); // R3
  AST_NO_DATA_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    (ext_req && ext_resp && (ext_mst_err != '0 || ext_slv_err)) |=> !ext_wr); // R10
  AST_ERRADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((mst_err_stat != '0 || slv_err_stat) && !clr_valid) |=> $stable(err_addr)); // R9
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((mst_err_stat != '0) && !clr_valid) |=> (mst_err_stat != '0)); // R8
endmodule

bind pcicfg_seq pcicfg_seq_chk #(.ADDR_W(ADDR_W), .MST_W(MST_W)) u_chk (.*);

// File: tb/pcicfg_seq_test.sv
module pcicfg_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  func;
    logic [7:0]  regno;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] eaddr;
    logic [3:0]  ebe;
    logic [31:0] eval;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd0, 5'd12, 3'd0, 8'h00, 3'd4, 32'h0,        32'h0000_1000, 4'b0000, 32'hC0DE_1000},
    '{1'b0, 8'd0, 5'd13, 3'd3, 8'h0E, 3'd2, 32'h0,        32'h0000_230C, 4'b0011, 32'h0000_C0DE},
    '{1'b0, 8'd1, 5'd3,  3'd1, 8'h09, 3'd1, 32'h0,        32'h0001_1909, 4'b1101, 32'h00C0_DF19},
    '{1'b1, 8'd0, 5'd14, 3'd0, 8'h13, 3'd1, 32'h0000_005A, 32'h0000_4010, 4'b0111, 32'h5A00_0000},
    '{1'b1, 8'd1, 5'd31, 3'd7, 8'h42, 3'd2, 32'h0000_BEEF, 32'h0001_FF41, 4'b0011, 32'hBEEF_0000},
    '{1'b1, 8'd0, 5'd15, 3'd2, 8'h20, 3'd4, 32'h1122_3344, 32'h0000_8220, 4'b0000, 32'h1122_3344},
    '{1'b0, 8'd1, 5'd0,  3'd0, 8'h01, 3'd2, 32'h0,        32'h0001_0001, 4'b1001, 32'h00C0_DF00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_func = '0;
  logic [7:0] req_reg = '0;
  logic [2:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic busy, done, rsp_err, rsp_illegal;
  logic [31:0] rsp_rdata;
  logic clr_valid = 1'b0;
  logic [1:0] clr_mst = '0;
  logic clr_slv = 1'b0;
  logic [1:0] mst_err_stat;
  logic slv_err_stat;
  logic [31:0] err_addr;
  logic ext_req, ext_wr, loc_req;
  logic [31:0] ext_addr, xfer_wdata, loc_cmd;
  logic [7:0] ext_cmd;
  logic ext_resp = 1'b0, ext_slv_err = 1'b0, loc_ack = 1'b0;
  logic [31:0] ext_rdata = '0, loc_rdata = '0;
  logic [1:0] ext_mst_err = '0;

  int n_setup = 0, n_wr = 0, n_loc = 0, n_done = 0;
  logic [31:0] last_addr = '0, last_wdata = '0, last_loc_cmd = '0, last_loc_wdata = '0;
  logic [7:0] last_cmd = '0;
  int total = 0, bad = 0;
  int cycles = 0;

  pcicfg_seq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus and local-space stubs, driven away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      ext_resp <= 1'b0;
      loc_ack  <= 1'b0;
    end else begin
      ext_resp <= ext_req && !ext_resp;
      if (ext_req && !ext_resp) begin
        logic hit;
        hit = ext_addr[0] ? (ext_addr[23:16] == 8'd1) : (ext_addr[15:12] != 4'h0);
        n_setup     <= n_setup + 1;
        last_addr   <= ext_addr;
        last_cmd    <= ext_cmd;
        ext_mst_err <= hit ? 2'b00 : 2'b10;
        ext_slv_err <= hit && (ext_addr[7:2] == 6'h3F);
        ext_rdata   <= ext_addr ^ 32'hC0DE_0000;
      end
      if (ext_wr) begin
        n_wr       <= n_wr + 1;
        last_wdata <= xfer_wdata;
      end
      loc_ack <= loc_req && !loc_ack;
      if (loc_req && !loc_ack) begin
        n_loc        <= n_loc + 1;
        last_loc_cmd <= loc_cmd;
        loc_rdata    <= 32'h1234_5678 ^ {24'h0, loc_cmd[7:0]};
        if (loc_cmd[16]) last_loc_wdata <= xfer_wdata;
      end
      if (done) n_done <= n_done + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] func, input logic [7:0] rg, input logic [2:0] size,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
    req_func = func; req_reg = rg; req_size = size; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 50 && !done; i++) @(negedge clk);
  endtask

  task automatic do_clear(input logic [1:0] m, input logic s);
    @(negedge clk);
    clr_valid = 1'b1; clr_mst = m; clr_slv = s;
    @(negedge clk);
    clr_valid = 1'b0; clr_mst = '0; clr_slv = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++;
        bad++;
        $display("FAIL watchdog R11 actual=%0d expected=%0d", cycles, 20000);
        finish_run();
      end
    end
  end

  initial begin
    int s0, w0, l0, d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check("R11 reset busy", {31'b0, busy}, 32'd0);
    check("R11 reset done", {31'b0, done}, 32'd0);
    check("R8 reset status", {29'b0, slv_err_stat, mst_err_stat}, 32'd0);
    check("R9 reset err_addr", err_addr, 32'd0);

    // Table-driven external accesses
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      v = VECS[k];
      w0 = n_wr;
      do_req(v.wr, v.bus, v.dev, v.func, v.regno, v.size, v.wdata);
      @(negedge clk);
      check(v.bus == 0 ? "R1 type0 addr" : "R2 type1 addr", last_addr, v.eaddr);
      check("R3 byte enables and code", {24'b0, last_cmd},
            {24'b0, v.ebe, v.wr ? 4'hB : 4'hA});
      check("R10 no error flagged", {31'b0, rsp_err}, 32'd0);
      if (v.wr) begin
        check("R6 write lanes", last_wdata, v.eval);
        check("R6 one data phase", n_wr - w0, 1);
      end else begin
        check("R7 read lanes", rsp_rdata, v.eval);
      end
    end

    // Local path read and write
    s0 = n_setup;
    do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h06, 3'd2, 32'h0);
    @(negedge clk);
    check("R5 local read cmd", last_loc_cmd, 32'h0030_0004);
    check("R7 local read data", rsp_rdata, 32'h0000_1234);
    do_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h01, 3'd1, 32'h0000_00AB);
    @(negedge clk);
    check("R5 local write cmd", last_loc_cmd, 32'h00D1_0000);
    check("R6 local write data", last_loc_wdata, 32'h0000_AB00);
    check("R5 no external setup", n_setup - s0, 0);

    // Illegal sizes
    s0 = n_setup; l0 = n_loc;
    do_req(1'b0, 8'd0, 5'd12, 3'd0, 8'h04, 3'd3, 32'h0);
    @(negedge clk);
    check("R4 illegal flag", {31'b0, rsp_illegal}, 32'd1);
    check("R4 illegal rdata", rsp_rdata, 32'hFFFF_FFFF);
    do_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h00, 3'd0, 32'h55);
    @(negedge clk);
    check("R4 illegal size 0", {31'b0, rsp_illegal}, 32'd1);
    check("R4 no bus activity", (n_setup - s0) + (n_loc - l0), 0);

    // Master abort on read
    do_req(1'b0, 8'd0, 5'd20, 3'd0, 8'h10, 3'd4, 32'h0);
    @(negedge clk);
    check("R10 abort rsp_err", {31'b0, rsp_err}, 32'd1);
    check("R10 abort rdata", rsp_rdata, 32'hFFFF_FFFF);
    check("R8 master status", {30'b0, mst_err_stat}, 32'd2);
    check("R9 first err_addr", err_addr, 32'h0010_0010);

    // Master abort on write, while status still set
    w0 = n_wr;
    do_req(1'b1, 8'd0, 5'd21, 3'd0, 8'h00, 3'd4, 32'h99);
    @(negedge clk);
    check("R10 write suppressed", n_wr - w0, 0);
    check("R10 write rsp_err", {31'b0, rsp_err}, 32'd1);
    check("R9 err_addr held", err_addr, 32'h0010_0010);

    // Clearing: wrong bit first, then the right one
    do_clear(2'b01, 1'b0);
    check("R8 wrong clear keeps", {30'b0, mst_err_stat}, 32'd2);
    do_clear(2'b10, 1'b0);
    check("R8 clear master", {30'b0, mst_err_stat}, 32'd0);

    // Slave-side error
    do_req(1'b0, 8'd1, 5'd2, 3'd0, 8'hFC, 3'd4, 32'h0);
    @(negedge clk);
    check("R8 slave status", {31'b0, slv_err_stat}, 32'd1);
    check("R9 new err_addr", err_addr, 32'h0001_10FD);
    check("R10 slave rdata", rsp_rdata, 32'hFFFF_FFFF);
    do_clear(2'b00, 1'b1);
    check("R8 clear slave", {31'b0, slv_err_stat}, 32'd0);

    // Request while busy is dropped
    s0 = n_setup; w0 = n_wr; d0 = n_done;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd12;
    req_func = 3'd0; req_reg = 8'h00; req_size = 3'd4;
    @(negedge clk);
    check("R11 busy after accept", {31'b0, busy}, 32'd1);
    req_write = 1'b1; req_dev = 5'd13; req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R11 one setup only", n_setup - s0, 1);
    check("R11 no dropped write", n_wr - w0, 0);
    check("R11 one done pulse", n_done - d0, 1);
    check("R11 idle again", {31'b0, busy}, 32'd0);

    finish_run();
  end
endmodule